// File: doc/BRIEF.md
# Dual-Channel Audio Sample FIFO

This block buffers byte samples for a two-channel sound engine. A processor writes bytes into two address windows over a simple memory-mapped bus. Each window feeds its own 1024-entry FIFO: channel A drives the left output and channel B drives the right output. A sample-rate strobe (about 22.257 kHz in the intended system) removes one byte from each channel and presents it on 16-bit outputs, scaled by 64.

An 8-bit event register records occupancy crossings and drives an interrupt line. The crossings are half-empty, nearly empty and nearly full. A variant input chooses between two policies. The default policy reports half-empty and empty separately for each channel. The alternate policy reports a single "channel A below half" condition that sets two bits together. Reading the event register returns its value and then clears it. A write to the mode register flushes both channels.

Top module: `asf_dual_fifo`

## Requirements
- R1: A bus write at an offset below 0x400 pushes the byte into channel A (left). A write at an offset from 0x400 to 0x7FF pushes the byte into channel B (right). Each channel delivers its bytes in the order they were written.
- R2: A cycle with `sample_tick` high pops one byte from each channel. In the following cycle, `out_left`/`out_right` show the byte zero-extended and multiplied by 64. The outputs hold their value in every cycle without a tick.
- R3: A tick on an empty channel sets that output to 0 and leaves the pointers unchanged, so the next byte written is the next byte popped.
- R4: A write into a channel that already holds 1024 bytes is dropped.
- R5: A write that leaves channel A holding 1023 bytes sets event bit 1. The same event on channel B sets bit 3. Neither event raises `irq`.
- R6: In the default variant (`variant_alt`=0), a pop that leaves channel A holding exactly 511 bytes sets bit 0. A pop that leaves exactly 1 byte sets bit 1. Both events raise `irq`.
- R7: In the default variant, the same crossings on channel B set bit 2 (511 bytes left) and bit 3 (1 byte left), and both raise `irq`.
- R8: In the alternate variant (`variant_alt`=1), every pop that leaves channel A holding fewer than 512 bytes sets bits 2 and 3 together and raises `irq`. Pops do not set bits 0 and 1 in this variant, and channel B pops set no bits.
- R9: A bus read at offset 0x804 returns the event register on `bus_rdata` in the next cycle. The read also clears all bits and `irq`. Events raised in the same cycle as the read survive the clear.
- R10: Any write to offset 0x801 empties both channels, resetting both pointers and both counts. A tick in that cycle is ignored and the outputs hold.
- R11: The pointers wrap modulo 1024, so data order is preserved across the wrap.
- R12: After reset, the outputs, `irq` and the event register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Bus byte offset |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| sample_tick | input | 1 | Sample-rate pop strobe |
| variant_alt | input | 1 | Selects the alternate event policy |
| out_left | output | 16 | Channel A sample times 64 |
| out_right | output | 16 | Channel B sample times 64 |
| irq | output | 1 | Interrupt, held until the event register is read |

## Verification
The event-register read can land in the same cycle as a pop that raises a crossing event. The bench provokes this by asserting `bus_rd` at offset 0x804 and `sample_tick` in a single cycle, while channel A holds 512 bytes. The expected result is that the read returns the old value (zero), `irq` stays high, and a second read returns bit 0 set. A flush write coinciding with a tick is also provoked; here the outputs must hold and the next tick must yield zero.

// File: rtl/asf_pkg.sv
package asf_pkg;
    // Event bit positions: software decodes these, so they are fixed.
    localparam int unsigned EV_A_HALF  = 0;
    localparam int unsigned EV_A_LOW   = 1;
    localparam int unsigned EV_A_FULL  = 1;
    localparam int unsigned EV_B_HALF  = 2;
    localparam int unsigned EV_B_LOW   = 3;
    localparam int unsigned EV_B_FULL  = 3;
    localparam int unsigned EV_W       = 8;

    typedef struct packed {
        logic [EV_W-1:0] flags;
        logic            irq;
    } ev_state_t;
endpackage

// File: rtl/asf_chan.sv
module asf_chan #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic              pop_fire,
    output logic [DATA_W-1:0] pop_data,
    output logic              push_fire,
    output logic [CNT_W-1:0]  level
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        st_d      = st_q;
        push_fire = push && !clr && (st_q.cnt != CNT_W'(DEPTH));
        pop_fire  = pop && !clr && (st_q.cnt != '0);
        if (clr) begin
            st_d = '0;
        end else begin
            if (push_fire) st_d.wp = st_q.wp + PTR_W'(1);
            if (pop_fire)  st_d.rp = st_q.rp + PTR_W'(1);
            st_d.cnt = st_q.cnt + CNT_W'(push_fire) - CNT_W'(pop_fire);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_fire) mem[st_q.wp] <= wdata;
    end

    assign pop_data = mem[st_q.rp];
    assign level    = st_q.cnt;
endmodule

// File: rtl/asf_events.sv
module asf_events
    import asf_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1,
    localparam int unsigned HALF_MARK = DEPTH / 2 - 1,
    localparam int unsigned LOW_LIMIT = DEPTH / 2,
    localparam int unsigned FULL_MARK = DEPTH - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt,
    input  logic             rd_clr,
    input  logic             a_pop,
    input  logic             a_push,
    input  logic [CNT_W-1:0] a_lvl,
    input  logic             b_pop,
    input  logic             b_push,
    input  logic [CNT_W-1:0] b_lvl,
    output logic [EV_W-1:0]  flags,
    output logic             irq
);
    ev_state_t st_d, st_q;
    logic [EV_W-1:0]  ev;
    logic             irq_ev;
    logic [CNT_W-1:0] a_after, b_after;

    always_comb begin
        a_after = a_lvl - CNT_W'(1);
        b_after = b_lvl - CNT_W'(1);
        ev      = '0;
        irq_ev  = 1'b0;
        if (a_push && (a_lvl + CNT_W'(1) == CNT_W'(FULL_MARK))) ev[EV_A_FULL] = 1'b1;
        if (b_push && (b_lvl + CNT_W'(1) == CNT_W'(FULL_MARK))) ev[EV_B_FULL] = 1'b1;
        if (!alt) begin
            if (a_pop && a_after == CNT_W'(HALF_MARK)) begin ev[EV_A_HALF] = 1'b1; irq_ev = 1'b1; end
            if (a_pop && a_after == CNT_W'(1))         begin ev[EV_A_LOW]  = 1'b1; irq_ev = 1'b1; end
            if (b_pop && b_after == CNT_W'(HALF_MARK)) begin ev[EV_B_HALF] = 1'b1; irq_ev = 1'b1; end
            if (b_pop && b_after == CNT_W'(1))         begin ev[EV_B_LOW]  = 1'b1; irq_ev = 1'b1; end
        end else if (a_pop && a_after < CNT_W'(LOW_LIMIT)) begin
            ev[EV_B_HALF] = 1'b1;
            ev[EV_B_LOW]  = 1'b1;
            irq_ev        = 1'b1;
        end
        st_d.flags = (rd_clr ? '0 : st_q.flags) | ev;
        st_d.irq   = (rd_clr ? 1'b0 : st_q.irq) | irq_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign irq   = st_q.irq;
endmodule

// File: rtl/asf_dual_fifo.sv
module asf_dual_fifo
    import asf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned DEPTH     = 1024,
    parameter int unsigned OUT_W     = 16,
    parameter int unsigned OUT_SHIFT = 6,
    parameter logic [11:0] MODE_ADDR = 12'h801,
    parameter logic [11:0] STAT_ADDR = 12'h804,
    localparam int unsigned CNT_W    = $clog2(DEPTH) + 1,
    localparam int unsigned NCH      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sample_tick,
    input  logic              variant_alt,
    output logic [OUT_W-1:0]  out_left,
    output logic [OUT_W-1:0]  out_right,
    output logic              irq
);
    typedef struct packed {
        logic [OUT_W-1:0]  left;
        logic [OUT_W-1:0]  right;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NCH-1:0]    push_v, pop_fire, push_fire;
    logic [DATA_W-1:0] pop_data [NCH];
    logic [CNT_W-1:0]  lvl [NCH];
    logic [CNT_W-1:0]  lvl_a, lvl_b;
    logic [EV_W-1:0]   flags;
    logic              mode_wr, stat_rd, win_a, win_b;

    assign win_a   = bus_addr < ADDR_W'(DEPTH);
    assign win_b   = !win_a && (bus_addr < ADDR_W'(2 * DEPTH));
    assign mode_wr = bus_wr && (bus_addr == ADDR_W'(MODE_ADDR));
    assign stat_rd = bus_rd && (bus_addr == ADDR_W'(STAT_ADDR));
    assign push_v  = {bus_wr && win_b, bus_wr && win_a};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        asf_chan #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (mode_wr),
            .push      (push_v[c]),
            .wdata     (bus_wdata),
            .pop       (sample_tick),
            .pop_fire  (pop_fire[c]),
            .pop_data  (pop_data[c]),
            .push_fire (push_fire[c]),
            .level     (lvl[c])
        );
    end

    assign lvl_a = lvl[0];
    assign lvl_b = lvl[1];

    asf_events #(.DEPTH(DEPTH)) u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .alt    (variant_alt),
        .rd_clr (stat_rd),
        .a_pop  (pop_fire[0]),
        .a_push (push_fire[0]),
        .a_lvl  (lvl_a),
        .b_pop  (pop_fire[1]),
        .b_push (push_fire[1]),
        .b_lvl  (lvl_b),
        .flags  (flags),
        .irq    (irq)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = stat_rd ? DATA_W'(flags) : '0;
        if (sample_tick && !mode_wr) begin
            st_d.left  = pop_fire[0] ? (OUT_W'(pop_data[0]) << OUT_SHIFT) : '0;
            st_d.right = pop_fire[1] ? (OUT_W'(pop_data[1]) << OUT_SHIFT) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_left  = st_q.left;
    assign out_right = st_q.right;
    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/asf_dual_fifo_chk.sv
module asf_dual_fifo_chk #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DEPTH     = 1024,
    parameter int unsigned OUT_W     = 16,
    parameter logic [11:0] MODE_ADDR = 12'h801,
    parameter logic [11:0] STAT_ADDR = 12'h804,
    localparam int unsigned CNT_W    = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              sample_tick,
    input logic [OUT_W-1:0]  out_left,
    input logic [OUT_W-1:0]  out_right,
    input logic              irq,
    input logic [CNT_W-1:0]  lvl_a,
    input logic [CNT_W-1:0]  lvl_b
);
    assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(out_left) || !$stable(out_right)) |-> $past(sample_tick));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_a <= CNT_W'(DEPTH)) && (lvl_b <= CNT_W'(DEPTH)));

    assert_irq_rise_on_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sample_tick));

    assert_irq_fall_by_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_rd && bus_addr == ADDR_W'(STAT_ADDR)));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(STAT_ADDR) && !sample_tick) |=> !irq);

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(MODE_ADDR)) |=> (lvl_a == '0 && lvl_b == '0));
endmodule

bind asf_dual_fifo asf_dual_fifo_chk #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .OUT_W(OUT_W),
    .MODE_ADDR(MODE_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .sample_tick(sample_tick),
    .out_left(out_left), .out_right(out_right), .irq(irq),
    .lvl_a(lvl_a), .lvl_b(lvl_b)
);

// File: tb/asf_dual_fifo_bench.sv
`timescale 1ns/1ps
module asf_dual_fifo_bench;
    localparam logic [11:0] MODE = 12'h801;
    localparam logic [11:0] STAT = 12'h804;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        sample_tick = 1'b0, variant_alt = 1'b0;
    logic [15:0] out_left, out_right;
    logic        irq;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    asf_dual_fifo u_asf_dual_fifo (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sample_tick(sample_tick), .variant_alt(variant_alt),
        .out_left(out_left), .out_right(out_right), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick();
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic rd_stat(output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = STAT;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic flush();
        logic [7:0] v;
        bwrite(MODE, 8'h01);
        rd_stat(v);
    endtask

    task automatic fill(input bit chan_b, input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++)
            bwrite((chan_b ? 12'h400 : 12'h000) + 12'(i % 1024), base + 8'(i));
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R12 left", 32'(out_left), 0);
        check("R12 right", 32'(out_right), 0);
        check("R12 irq", 32'(irq), 0);
        rd_stat(v);
        check("R12 events", 32'(v), 0);
    endtask

    task automatic t_order();
        flush();
        bwrite(12'h000, 8'h11);
        bwrite(12'h3FF, 8'h22);
        bwrite(12'h5A0, 8'h33);
        tick();
        check("R1 R2 left first", 32'(out_left), 32'h440);
        check("R1 R2 right first", 32'(out_right), 32'hCC0);
        repeat (3) @(negedge clk);
        check("R2 hold", 32'(out_left), 32'h440);
        tick();
        check("R1 left second", 32'(out_left), 32'h880);
        check("R3 right empty", 32'(out_right), 0);
        tick();
        check("R3 left empty", 32'(out_left), 0);
        bwrite(12'h010, 8'h55);
        tick();
        check("R3 pointer kept", 32'(out_left), 32'h1540);
    endtask

    task automatic t_default_events();
        logic [7:0] v;
        flush();
        variant_alt = 1'b0;
        fill(1'b0, 512, 8'h00);
        fill(1'b1, 512, 8'h80);
        rd_stat(v);
        check("R5 no event below 1023", 32'(v), 0);
        tick();
        check("R6 irq raised", 32'(irq), 1);
        rd_stat(v);
        check("R6 R7 half events", 32'(v), 32'h05);
        check("R9 irq cleared", 32'(irq), 0);
        repeat (509) tick();
        rd_stat(v);
        check("R6 exact crossings only", 32'(v), 0);
        tick();
        check("R7 irq on low", 32'(irq), 1);
        rd_stat(v);
        check("R6 R7 low events", 32'(v), 32'h0A);
        tick();
        rd_stat(v);
        check("R6 no event at zero", 32'(v), 0);
    endtask

    task automatic t_alt_events();
        logic [7:0] v;
        flush();
        variant_alt = 1'b1;
        fill(1'b0, 513, 8'h00);
        fill(1'b1, 513, 8'h00);
        tick();
        rd_stat(v);
        check("R8 not below half", 32'(v), 0);
        tick();
        check("R8 irq", 32'(irq), 1);
        rd_stat(v);
        check("R8 two bits", 32'(v), 32'h0C);
        tick();
        rd_stat(v);
        check("R8 repeats below half", 32'(v), 32'h0C);
        variant_alt = 1'b0;
    endtask

    task automatic t_collide();
        logic [7:0] v;
        flush();
        fill(1'b0, 512, 8'h00);
        bus_rd = 1'b1; bus_addr = STAT; sample_tick = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; sample_tick = 1'b0;
        check("R9 read returns old", 32'(bus_rdata), 0);
        check("R9 event survives irq", 32'(irq), 1);
        rd_stat(v);
        check("R9 event survives flag", 32'(v), 32'h01);
    endtask

    task automatic t_full_wrap();
        logic [7:0] v;
        flush();
        fill(1'b0, 1022, 8'h00);
        rd_stat(v);
        check("R5 none at 1022", 32'(v), 0);
        bwrite(12'h3FE, 8'hFE);
        check("R5 no irq", 32'(irq), 0);
        rd_stat(v);
        check("R5 full A", 32'(v), 32'h02);
        bwrite(12'h3FF, 8'hFF);
        bwrite(12'h123, 8'hEE);
        for (int i = 0; i < 1024; i++) begin
            tick();
            check("R4 R11 drain order", 32'(out_left), 32'(i % 256) * 64);
        end
        tick();
        check("R4 dropped write", 32'(out_left), 0);
        bwrite(12'h000, 8'h77);
        tick();
        check("R11 after wrap", 32'(out_left), 32'h1DC0);
        flush();
        fill(1'b1, 1023, 8'h00);
        rd_stat(v);
        check("R5 full B", 32'(v), 32'h08);
    endtask

    task automatic t_flush();
        flush();
        fill(1'b0, 3, 8'h40);
        tick();
        check("R10 pre", 32'(out_left), 32'h1000);
        bus_wr = 1'b1; bus_addr = MODE; bus_wdata = 8'h00; sample_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; sample_tick = 1'b0;
        check("R10 tick ignored", 32'(out_left), 32'h1000);
        tick();
        check("R10 emptied", 32'(out_left), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_default_events();
        t_alt_events();
        t_collide();
        t_full_wrap();
        t_flush();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule